// File: doc/BRIEF.md
# Memory Self-Test Write Pattern Generator

This block fills a region of memory with a known pattern so that a later read pass can check it. After a start pulse it writes a run of full-width words into a byte-addressed window described by a base address, an end address and a length in bytes. Each word carries either a counter value or a pseudo-random value. Both are derived from the word's position in the run, so a checker can regenerate any word without storing it.

Every write has two transfers on the memory port. The command transfer (valid/ready) carries the write flag and the word address. The data transfer (valid/ready) follows and carries the word with every byte enabled. On either channel the memory may hold ready low for any number of cycles. The block then keeps valid high, and keeps the address or data unchanged, until the handshake completes. The two channels are never valid in the same cycle.

The `done` output is a level. It rises after the last data transfer and stays high until the next accepted start. A start pulse that arrives while the block is busy is dropped.

Top module: `mbist_wgen`

## Requirements
- R1: After reset `cmd_valid`, `wdata_valid`, `busy` and `done` are all 0.
- R2: In counter mode (`rand_mode`=0) the word with run index k is made of NCH=DATA_W/32 chunks. Chunk c holds k*NCH+c. Chunk 0 occupies the most significant 32 bits, and chunk NCH-1 the least significant.
- R3: In random mode (`rand_mode`=1) each chunk holds (s*0x31415979+1) mod 2^32, where s is the seed k*NCH+c from R2. Chunks are placed as in R2.
- R4: A run writes `run_len`/(DATA_W/8) words, rounded down. The first word goes to byte address `base_addr` with index 0, and each following word goes one word further on with the next index. Memory words the run does not reach keep their previous contents.
- R5: The byte offset from `base_addr` wraps modulo (`end_addr`-`base_addr`), which must be a power of two. Once the run is longer than the window, it overwrites the start of the window.
- R6: A command transfer has `cmd_we`=1 and `cmd_addr` equal to the byte address shifted right by log2(DATA_W/8). `cmd_valid` and `cmd_addr` stay stable until `cmd_ready` is sampled high.
- R7: The cycle after a command is accepted, `wdata_valid` rises with the word and with `wdata_be` all ones. Both stay stable until `wdata_ready` is sampled high. `cmd_valid` and `wdata_valid` are never high together.
- R8: `start` is ignored while `busy` is 1. `done` rises the cycle after the last data transfer and clears when a start is accepted. A run of zero words completes with `done`=1 and issues no transfer.
- R9: `busy` is 1 from the cycle after an accepted start until the cycle in which `done` rises, and `done` and `busy` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| rand_mode | input | 1 | 1: pseudo-random data, 0: counter data |
| base_addr | input | BA_W | First byte address of the window |
| end_addr | input | BA_W | Byte address one past the window |
| run_len | input | BA_W | Bytes to write |
| cmd_valid | output | 1 | Command transfer valid |
| cmd_ready | input | 1 | Command transfer ready |
| cmd_we | output | 1 | Write flag, always 1 for this block |
| cmd_addr | output | ADDR_W | Word address |
| wdata_valid | output | 1 | Data transfer valid |
| wdata_ready | input | 1 | Data transfer ready |
| wdata_data | output | DATA_W | Write word |
| wdata_be | output | DATA_W/8 | Byte enables, all ones |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |

## Verification
A fresh start pulse can fall in the same cycle as the final data handshake of the current run. The bench forces this case by raising `start` exactly when it grants `wdata_ready` to the last word. It then requires three things: exactly the expected number of writes, `done` going high and staying high, and a memory image with no trace of the second run's parameters. A separate start is also sent mid-run with different parameters, and it is judged the same way. Both runs are made under irregular back-pressure on the two channels, so the command and data handshakes sit at varied cycle offsets from the start pulse.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } mbist_st_e;

  localparam logic [31:0] LCG_MUL = 32'h3141_5979;
  localparam logic [31:0] LCG_ADD = 32'd1;
endpackage

// File: rtl/mbist_seed_gen.sv
module mbist_seed_gen #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 32
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              rnd,
  output logic [DATA_W-1:0] word
);
  import mbist_pkg::*;
  localparam int NCH = DATA_W / 32;

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    logic [31:0] seed;
    logic [31:0] val;
    always_comb begin
      seed = 32'(idx * NCH) + 32'(c);
      val  = rnd ? (seed * LCG_MUL + LCG_ADD) : seed;
    end
    // chunk 0 lands in the top 32 bits
    assign word[DATA_W-1-32*c -: 32] = val;
  end
endmodule

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
  parameter int BA_W   = 32,
  parameter int ADDR_W = 28,
  parameter int BPW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [BA_W-1:0]   base_i,
  input  logic [BA_W-1:0]   span_i,
  input  logic [BA_W-1:0]   words_i,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BA_W-1:0]   idx,
  output logic              last
);
  localparam int SH = $clog2(BPW);

  logic [BA_W-1:0] base_q, mask_q, off_q, nw_q;
  logic [BA_W-1:0] byte_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      off_q  <= '0;
      nw_q   <= '0;
      idx    <= '0;
    end else if (load) begin
      base_q <= base_i;
      mask_q <= span_i - BA_W'(1);
      off_q  <= '0;
      nw_q   <= words_i;
      idx    <= '0;
    end else if (step) begin
      off_q  <= (off_q + BA_W'(BPW)) & mask_q;
      idx    <= idx + BA_W'(1);
    end
  end

  assign byte_addr = base_q + off_q;
  assign word_addr = ADDR_W'(byte_addr >> SH);
  assign last      = (idx == nw_q - BA_W'(1));
endmodule

// File: rtl/mbist_wgen.sv
module mbist_wgen #(
  parameter int DATA_W = 64,
  parameter int BA_W   = 32,
  parameter int ADDR_W = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rand_mode,
  input  logic [BA_W-1:0]     base_addr,
  input  logic [BA_W-1:0]     end_addr,
  input  logic [BA_W-1:0]     run_len,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic                cmd_we,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic                wdata_valid,
  input  logic                wdata_ready,
  output logic [DATA_W-1:0]   wdata_data,
  output logic [DATA_W/8-1:0] wdata_be,
  output logic                busy,
  output logic                done
);
  import mbist_pkg::*;
  localparam int BPW = DATA_W / 8;
  localparam int SH  = $clog2(BPW);

  mbist_st_e       st_q;
  logic            rnd_q;
  logic            accept, load, step, last;
  logic [BA_W-1:0] words, idx;

  assign words  = run_len >> SH;
  assign accept = start && (st_q == ST_IDLE);
  assign load   = accept;
  assign step   = (st_q == ST_DATA) && wdata_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rnd_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          rnd_q <= rand_mode;
          if (words == '0) begin
            done <= 1'b1;
          end else begin
            done <= 1'b0;
            st_q <= ST_CMD;
          end
        end
        ST_CMD: if (cmd_ready) st_q <= ST_DATA;
        ST_DATA: if (wdata_ready) begin
          if (last) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st_q <= ST_CMD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  mbist_addr_seq #(.BA_W(BA_W), .ADDR_W(ADDR_W), .BPW(BPW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .base_i    (base_addr),
    .span_i    (end_addr - base_addr),
    .words_i   (words),
    .word_addr (cmd_addr),
    .idx       (idx),
    .last      (last)
  );

  mbist_seed_gen #(.DATA_W(DATA_W), .IDX_W(BA_W)) u_gen (
    .idx  (idx),
    .rnd  (rnd_q),
    .word (wdata_data)
  );

  assign cmd_valid   = (st_q == ST_CMD);
  assign cmd_we      = 1'b1;
  assign wdata_valid = (st_q == ST_DATA);
  assign wdata_be    = '1;
  assign busy        = (st_q != ST_IDLE);
endmodule

// File: rtl/mbist_wgen_chk.sv
module mbist_wgen_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                cmd_we,
  input logic [ADDR_W-1:0]   cmd_addr,
  input logic                wdata_valid,
  input logic                wdata_ready,
  input logic [DATA_W-1:0]   wdata_data,
  input logic [DATA_W/8-1:0] wdata_be,
  input logic                busy,
  input logic                done
);
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr));
  a_r6_we_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_we);
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_valid && !wdata_ready |=> wdata_valid && $stable(wdata_data));
  a_r7_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> wdata_valid);
  a_r7_be_full: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_valid |-> (&wdata_be));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wdata_valid));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  a_r9_busy_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || wdata_valid) |-> busy);
endmodule

bind mbist_wgen mbist_wgen_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_we      (cmd_we),
  .cmd_addr    (cmd_addr),
  .wdata_valid (wdata_valid),
  .wdata_ready (wdata_ready),
  .wdata_data  (wdata_data),
  .wdata_be    (wdata_be),
  .busy        (busy),
  .done        (done)
);

// File: tb/tb_mbist_wgen.sv
module tb_mbist_wgen;
  localparam int DATA_W = 64;
  localparam int BA_W   = 32;
  localparam int ADDR_W = 6;
  localparam int NW     = 1 << ADDR_W;
  localparam int BPW    = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rand_mode = 1'b0;
  logic [BA_W-1:0] base_addr = '0, end_addr = '0, run_len = '0;
  logic cmd_valid, cmd_we, wdata_valid, busy, done;
  logic cmd_ready = 1'b0, wdata_ready = 1'b0;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] wdata_data;
  logic [DATA_W/8-1:0] wdata_be;

  always #4 clk = ~clk;

  mbist_wgen #(.DATA_W(DATA_W), .BA_W(BA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rand_mode(rand_mode),
    .base_addr(base_addr), .end_addr(end_addr), .run_len(run_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
    .wdata_data(wdata_data), .wdata_be(wdata_be), .busy(busy), .done(done));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DATA_W-1:0] mem [NW];
  logic [DATA_W-1:0] exp_mem [NW];
  int r_base, r_span, r_words;
  int ncmd = 0, ndat = 0;
  int kick_req = 0, kick_seen = 0;
  bit trig_on_last = 0, stall = 1;
  int cyc = 0;
  logic [ADDR_W-1:0] last_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] gen(input int k, input bit r);
    logic [DATA_W-1:0] w;
    for (int c = 0; c < DATA_W / 32; c++) begin
      logic [31:0] s;
      s = 32'(k * (DATA_W / 32) + c);
      w[DATA_W-1-32*c -: 32] = r ? (s * 32'h3141_5979 + 32'd1) : s;
    end
    return w;
  endfunction

  // memory responder: drives ready and start, records handshakes
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      cmd_ready   = stall ? ((cyc % 3) != 0) : 1'b1;
      wdata_ready = stall ? ((cyc % 4) != 1) : 1'b1;
      start = (kick_req != kick_seen);
      kick_seen = kick_req;
      if (cmd_valid && cmd_ready) begin
        chk(cmd_addr == ADDR_W'((r_base + ((ncmd * BPW) % r_span)) / BPW),
            "R6", "cmd_addr", cmd_addr,
            (r_base + ((ncmd * BPW) % r_span)) / BPW);
        last_addr = cmd_addr;
        ncmd++;
      end
      if (wdata_valid && wdata_ready) begin
        chk(&wdata_be, "R7", "byte enable", wdata_be, '1);
        mem[last_addr] = wdata_data;
        if (trig_on_last && ndat == r_words - 1) start = 1'b1;
        ndat++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run(input bit rnd, input int b, input int e, input int len,
                     input bit mid_kick, input bit on_last);
    int n;
    r_base = b; r_span = e - b; r_words = len / BPW;
    ncmd = 0; ndat = 0;
    rand_mode = rnd; base_addr = b; end_addr = e; run_len = len;
    trig_on_last = on_last;
    kick_req++;
    n = 0;
    if (r_words > 0) begin
      while (!busy && n < 50) begin @(negedge clk); n++; end
      chk(busy && !done, "R8", "done cleared on start", done, 0);
      if (mid_kick) begin
        while (ncmd < 2) @(negedge clk);
        base_addr = 0; end_addr = 64; run_len = 64; rand_mode = ~rnd;
        kick_req++;
      end
    end else begin
      repeat (4) @(negedge clk);
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    chk(done && !busy, "R9", "done level, busy low", {done, busy}, 2'b10);
    chk(ndat == r_words, "R4", "write count", ndat, r_words);
    chk(ncmd == r_words, "R8", "no extra command", ncmd, r_words);
    for (int k = 0; k < r_words; k++)
      exp_mem[(r_base + ((k * BPW) % r_span)) / BPW] = gen(k, rnd);
    for (int a = 0; a < NW; a++)
      chk(mem[a] == exp_mem[a], rnd ? "R3" : "R2", $sformatf("word %0d", a),
          mem[a], exp_mem[a]);
    trig_on_last = 0;
  endtask

  initial begin
    for (int a = 0; a < NW; a++) begin
      mem[a] = {32'hA5A5_0000 | 32'(a), 32'h5A5A_0000 | 32'(a)};
      exp_mem[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !wdata_valid && !busy && !done, "R1", "reset idle",
        {cmd_valid, wdata_valid, busy, done}, 0);
    // R2/R4: counter data, five words from byte 16
    run(0, 16, 80, 40, 0, 0);
    // R3/R5: random data, six words in a four-word window
    run(1, 16, 48, 48, 0, 0);
    // R8: zero-word run
    run(0, 0, 64, 4, 0, 0);
    // R8: start mid-run and on the final data handshake are dropped
    run(0, 256, 320, 32, 1, 1);
    // R3/R6: no back-pressure, top of memory
    stall = 0;
    run(1, 448, 512, 64, 0, 1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule